// File: doc/BRIEF.md
# Hypervisor Stage-1 TLB Invalidate-All Unit

This block executes the system instruction that discards every cached stage-1 translation belonging to the hypervisor regimes of the current security state. It receives the decoded instruction fields together with the core's exception level and its configuration bits. It then decides whether the access is undefined, is trapped to the hypervisor with a syndrome class, or executes. An executing invalidate walks a small fully associative tag array one entry per clock. It clears the entries that match and raises a request so that the other cores in the outer shareable domain perform the same invalidation.

The tag array is loaded through a fill port, and its valid bits are visible on an output. The unit takes one instruction at a time. While a sweep is in progress it ignores new instructions. Address translation and table walks belong elsewhere.

Top module: `tlbinv_top`

## Requirements
- R1: An access is recognised only when `op0`=1, `op1`=4, `crn`=8, `crm`=1, `op2`=0 and `feat_impl`=1. Any other access is undefined: `undef_o` pulses for one cycle, in the cycle after the request.
- R2: With `cur_el`=0 (codes 0..3 name EL0..EL3), a recognised access is always undefined.
- R3: With `cur_el`=1, a recognised access traps when `el2_en`=1 and `nv`=1. The trap shows as a one-cycle `trap_o` pulse with `trap_ec`=0x18. Without both bits set, the access is undefined.
- R4: With `cur_el`=2, a recognised access always executes. With `cur_el`=3, it executes only when `el2_en`=1 and is undefined otherwise.
- R5: A sweep clears an entry only when all of the following hold: the entry is valid, it is stage 1 (stage bit 0, where 1 means stage 2), and its regime code is 1 (EL2) or 2 (EL2&0). Regime codes 0 (EL1&0) and 3 (EL3), and stage-2 entries, keep their valid bit.
- R6: With `ns`=1 only entries whose secure tag is 0 are cleared. With `ns`=0 only entries whose secure tag is 1 are cleared. The value used is the one `ns` had when the instruction was accepted.
- R7: An undefined or trapped access changes no entry and raises no broadcast request.
- R8: An executing access sets `busy` from the next cycle for exactly ENTRIES cycles. During those cycles the unit examines entries 0, 1, … in turn. `clr_vec` is one-hot on the entry being cleared, or zero.
- R9: `done` is high for exactly one cycle: the first cycle after the last entry was examined, which is also the cycle in which `busy` falls.
- R10: A request that arrives while `busy` is high produces no pulse, no trap and no sweep.
- R11: `bcast_req` rises together with `busy` and stays high until a cycle in which `bcast_ack` is 1. It is low from the following cycle.
- R12: A fill with `fill_en`=1 writes the stage, regime and secure tags into entry `fill_idx` and sets its valid bit. The new value is seen on `valid_vec` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction issued this cycle |
| op0 | input | 2 | Instruction field op0 |
| op1 | input | 3 | Instruction field op1 |
| crn | input | 4 | Instruction field CRn |
| crm | input | 4 | Instruction field CRm |
| op2 | input | 3 | Instruction field op2 |
| cur_el | input | 2 | Current exception level, 0..3 |
| el2_en | input | 1 | Hypervisor level enabled in the current security state |
| ns | input | 1 | Non-secure state bit |
| nv | input | 1 | Nested-virtualization trap bit |
| feat_impl | input | 1 | Feature implemented |
| fill_en | input | 1 | Write one tag entry |
| fill_idx | input | clog2(ENTRIES) | Entry index to write |
| fill_stage2 | input | 1 | Stage tag, 1 = stage 2 |
| fill_regime | input | 2 | Regime tag: 0 EL1&0, 1 EL2, 2 EL2&0, 3 EL3 |
| fill_secure | input | 1 | Security tag, 1 = secure |
| bcast_ack | input | 1 | Acknowledge from the shareability fabric |
| undef_o | output | 1 | Undefined-instruction pulse |
| trap_o | output | 1 | Trap-to-hypervisor pulse |
| trap_ec | output | 6 | Syndrome exception class while trap_o is high |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished pulse |
| clr_vec | output | ENTRIES | Per-entry valid clear this cycle |
| valid_vec | output | ENTRIES | Valid bits of the tag array |
| bcast_req | output | 1 | Broadcast invalidate request |

## Verification
The bound checker covers the properties that hold on every cycle. Undefined and trap never occur together, and a trap always carries class 0x18 after an EL1 access with both enable bits set. No valid bit falls unless its clear strobe fired. Clears appear only during a sweep and are at most one-hot, and `done` is a single-cycle pulse that coincides with the fall of `busy`. The broadcast request rises with `busy` and is held until it is acknowledged. Only the bench scenarios can show which entries a sweep must clear for each security state and tag mix, and that the clears come in ascending order. They also show that the `ns` value captured at acceptance wins over a later change, and that refused or busy-time requests leave the array untouched.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

  typedef enum logic [1:0] {
    RG_EL10 = 2'd0,
    RG_EL2  = 2'd1,
    RG_EL20 = 2'd2,
    RG_EL3  = 2'd3
  } regime_e;

  typedef enum logic [1:0] {
    AC_NONE  = 2'd0,
    AC_UNDEF = 2'd1,
    AC_TRAP  = 2'd2,
    AC_EXEC  = 2'd3
  } access_e;

  typedef struct packed {
    logic    valid;
    logic    stage2;
    regime_e regime;
    logic    secure;
  } tag_t;

  localparam logic [1:0] ENC_OP0 = 2'b01;
  localparam logic [2:0] ENC_OP1 = 3'b100;
  localparam logic [3:0] ENC_CRN = 4'b1000;
  localparam logic [3:0] ENC_CRM = 4'b0001;
  localparam logic [2:0] ENC_OP2 = 3'b000;

  localparam logic [5:0] EC_SYSINSN_TRAP = 6'h18;

endpackage

// File: rtl/tlbinv_access.sv
module tlbinv_access
  import tlbinv_pkg::*;
(
  input  logic       req_i,
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  logic [1:0] el_i,
  input  logic       el2_en_i,
  input  logic       nv_i,
  input  logic       feat_i,
  output access_e    acc_o
);

  logic enc_hit;

  assign enc_hit = (op0_i == ENC_OP0) && (op1_i == ENC_OP1) &&
                   (crn_i == ENC_CRN) && (crm_i == ENC_CRM) &&
                   (op2_i == ENC_OP2);

  always_comb begin
    acc_o = AC_NONE;
    if (req_i) begin
      if (!enc_hit || !feat_i) begin
        acc_o = AC_UNDEF;
      end else begin
        unique case (el_i)
          2'd0: acc_o = AC_UNDEF;
          2'd1: acc_o = (el2_en_i && nv_i) ? AC_TRAP : AC_UNDEF;
          2'd2: acc_o = AC_EXEC;
          2'd3: acc_o = el2_en_i ? AC_EXEC : AC_UNDEF;
          default: acc_o = AC_UNDEF;
        endcase
      end
    end
  end

endmodule

// File: rtl/tlbinv_sweep.sv
module tlbinv_sweep #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(ENTRIES - 1);

  logic          run_q, run_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;

  always_comb begin
    run_d  = run_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (!run_q) begin
      if (start_i) begin
        run_d = 1'b1;
        idx_d = '0;
      end
    end else if (idx_q == LAST_IDX) begin
      run_d  = 1'b0;
      done_d = 1'b1;
    end else begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign busy_o = run_q;
  assign idx_o  = idx_q;
  assign done_o = done_q;

endmodule

// File: rtl/tlbinv_tags.sv
module tlbinv_tags
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en_i,
  input  logic [IW-1:0]      fill_idx_i,
  input  tag_t               fill_tag_i,
  input  logic               sweep_act_i,
  input  logic [IW-1:0]      sweep_idx_i,
  input  logic               sweep_ns_i,
  output logic [ENTRIES-1:0] clr_o,
  output logic [ENTRIES-1:0] valid_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    tag_t tag_q, tag_d;
    logic here, regime_hit, sec_hit, wr;

    assign here       = sweep_act_i && (sweep_idx_i == IW'(g));
    assign regime_hit = (tag_q.regime == RG_EL2) || (tag_q.regime == RG_EL20);
    assign sec_hit    = (tag_q.secure == !sweep_ns_i);
    assign clr_o[g]   = here && tag_q.valid && !tag_q.stage2 && regime_hit && sec_hit;
    assign wr         = fill_en_i && (fill_idx_i == IW'(g));

    always_comb begin
      tag_d = tag_q;
      if (clr_o[g]) begin
        tag_d.valid = 1'b0;
      end
      if (wr) begin
        tag_d       = fill_tag_i;
        tag_d.valid = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= '0;
      end else if (wr || clr_o[g]) begin
        tag_q <= tag_d;
      end
    end

    assign valid_o[g] = tag_q.valid;
  end

endmodule

// File: rtl/tlbinv_bcast.sv
module tlbinv_bcast (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic ack_i,
  output logic req_o
);

  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (set_i) begin
      req_d = 1'b1;
    end else if (ack_i) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/tlbinv_top.sv
module tlbinv_top
  import tlbinv_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         op0,
  input  logic [2:0]         op1,
  input  logic [3:0]         crn,
  input  logic [3:0]         crm,
  input  logic [2:0]         op2,
  input  logic [1:0]         cur_el,
  input  logic               el2_en,
  input  logic               ns,
  input  logic               nv,
  input  logic               feat_impl,
  input  logic               fill_en,
  input  logic [IW-1:0]      fill_idx,
  input  logic               fill_stage2,
  input  logic [1:0]         fill_regime,
  input  logic               fill_secure,
  input  logic               bcast_ack,
  output logic               undef_o,
  output logic               trap_o,
  output logic [5:0]         trap_ec,
  output logic               busy,
  output logic               done,
  output logic [ENTRIES-1:0] clr_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic               bcast_req
);

  logic          busy_w;
  logic          req_gated;
  logic          accept;
  access_e       acc;
  logic [IW-1:0] sweep_idx;
  tag_t          fill_tag;

  logic undef_q, undef_d;
  logic trap_q, trap_d;
  logic ns_q, ns_d;

  assign req_gated = req_valid && !busy_w;

  tlbinv_access u_access (
    .req_i    (req_gated),
    .op0_i    (op0),
    .op1_i    (op1),
    .crn_i    (crn),
    .crm_i    (crm),
    .op2_i    (op2),
    .el_i     (cur_el),
    .el2_en_i (el2_en),
    .nv_i     (nv),
    .feat_i   (feat_impl),
    .acc_o    (acc)
  );

  assign accept = (acc == AC_EXEC);

  always_comb begin
    undef_d = (acc == AC_UNDEF);
    trap_d  = (acc == AC_TRAP);
    ns_d    = accept ? ns : ns_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      undef_q <= 1'b0;
      trap_q  <= 1'b0;
      ns_q    <= 1'b0;
    end else begin
      undef_q <= undef_d;
      trap_q  <= trap_d;
      ns_q    <= ns_d;
    end
  end

  tlbinv_sweep #(.ENTRIES(ENTRIES)) u_sweep (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept),
    .busy_o  (busy_w),
    .idx_o   (sweep_idx),
    .done_o  (done)
  );

  always_comb begin
    fill_tag        = '0;
    fill_tag.valid  = 1'b1;
    fill_tag.stage2 = fill_stage2;
    fill_tag.regime = regime_e'(fill_regime);
    fill_tag.secure = fill_secure;
  end

  tlbinv_tags #(.ENTRIES(ENTRIES)) u_tags (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_en_i   (fill_en),
    .fill_idx_i  (fill_idx),
    .fill_tag_i  (fill_tag),
    .sweep_act_i (busy_w),
    .sweep_idx_i (sweep_idx),
    .sweep_ns_i  (ns_q),
    .clr_o       (clr_vec),
    .valid_o     (valid_vec)
  );

  tlbinv_bcast u_bcast (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (accept),
    .ack_i (bcast_ack),
    .req_o (bcast_req)
  );

  assign busy    = busy_w;
  assign undef_o = undef_q;
  assign trap_o  = trap_q;
  assign trap_ec = trap_q ? EC_SYSINSN_TRAP : 6'h00;

endmodule

// File: rtl/tlbinv_chk.sv
module tlbinv_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [1:0]         cur_el,
  input logic               el2_en,
  input logic               nv,
  input logic               busy,
  input logic               done,
  input logic               undef_o,
  input logic               trap_o,
  input logic [5:0]         trap_ec,
  input logic [ENTRIES-1:0] clr_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               bcast_req,
  input logic               bcast_ack
);

  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_o && trap_o));

  // R3
  trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (trap_ec == 6'h18));

  // R3
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> ($past(cur_el) == 2'd1 && $past(el2_en) && $past(nv)));

  // R2
  el0_never_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && cur_el == 2'd0) |=> (!trap_o && !busy && !bcast_req));

  // R7
  no_silent_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(valid_vec) & ~valid_vec) & ~$past(clr_vec)) == '0));

  // R8
  clr_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |-> (busy && $onehot0(clr_vec)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R11
  bcast_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bcast_req);

  // R11
  bcast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcast_req && !bcast_ack && !busy) |=> bcast_req);

endmodule

bind tlbinv_top tlbinv_chk #(.ENTRIES(ENTRIES)) u_tlbinv_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .cur_el    (cur_el),
  .el2_en    (el2_en),
  .nv        (nv),
  .busy      (busy),
  .done      (done),
  .undef_o   (undef_o),
  .trap_o    (trap_o),
  .trap_ec   (trap_ec),
  .clr_vec   (clr_vec),
  .valid_vec (valid_vec),
  .bcast_req (bcast_req),
  .bcast_ack (bcast_ack)
);

// File: tb/tlbinv_top_bench.sv
module tlbinv_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk, rst_n, req_valid;
  logic [1:0] op0; logic [2:0] op1; logic [3:0] crn, crm; logic [2:0] op2;
  logic [1:0] cur_el;
  logic el2_en, ns, nv, feat_impl;
  logic fill_en; logic [IW-1:0] fill_idx; logic fill_stage2; logic [1:0] fill_regime; logic fill_secure;
  logic bcast_ack;
  logic undef_o, trap_o, busy, done, bcast_req;
  logic [5:0] trap_ec;
  logic [N-1:0] clr_vec, valid_vec;

  tlbinv_top #(.ENTRIES(N)) u_tlbinv_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .op0(op0), .op1(op1), .crn(crn), .crm(crm), .op2(op2),
    .cur_el(cur_el), .el2_en(el2_en), .ns(ns), .nv(nv), .feat_impl(feat_impl),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_stage2(fill_stage2),
    .fill_regime(fill_regime), .fill_secure(fill_secure), .bcast_ack(bcast_ack),
    .undef_o(undef_o), .trap_o(trap_o), .trap_ec(trap_ec), .busy(busy), .done(done),
    .clr_vec(clr_vec), .valid_vec(valid_vec), .bcast_req(bcast_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // scoreboard: 1 undefined, 2 trap, 3 sweep done
  int           exp_kind[$];
  logic [N-1:0] exp_valid[$];

  // model of the tag array, built from R12
  logic [N-1:0] m_valid;
  logic         m_st2[N];
  logic [1:0]   m_rg[N];
  logic         m_sec[N];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // monitor: pops expected outcomes, checks the sweep order
  int sw_cyc = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (busy) begin
        if (clr_vec != '0)
          chk(clr_vec == N'(1 << sw_cyc), "R8 ascending one-hot clear", 64'(clr_vec), 64'(1 << sw_cyc));
        sw_cyc++;
      end else begin
        if (done) chk(sw_cyc == N, "R8 busy length", 64'(sw_cyc), 64'(N));
        sw_cyc = 0;
      end
      if (undef_o || trap_o || done) begin
        if (exp_kind.size() == 0) begin
          chk(1'b0, "R10 unexpected outcome", {61'd0, done, trap_o, undef_o}, 64'd0);
        end else begin
          int k;
          logic [N-1:0] ev;
          k  = exp_kind.pop_front();
          ev = exp_valid.pop_front();
          chk(undef_o == (k == 1), "R1 undefined pulse", 64'(undef_o), 64'(k == 1));
          chk(trap_o == (k == 2), "R3 trap pulse", 64'(trap_o), 64'(k == 2));
          chk(done == (k == 3), "R9 done pulse", 64'(done), 64'(k == 3));
          if (k == 2) chk(trap_ec == 6'h18, "R3 syndrome class", 64'(trap_ec), 64'h18);
          if (k == 3) chk(valid_vec == ev, "R5 R6 valid after sweep", 64'(valid_vec), 64'(ev));
        end
      end
    end
  end

  task automatic fill(input int i, input bit st2, input logic [1:0] rg, input bit sec);
    fill_en = 1; fill_idx = IW'(i); fill_stage2 = st2; fill_regime = rg; fill_secure = sec;
    tick();
    fill_en = 0;
    m_valid[i] = 1'b1; m_st2[i] = st2; m_rg[i] = rg; m_sec[i] = sec;
  endtask

  function automatic logic [N-1:0] swept(input bit nsb);
    logic [N-1:0] v;
    v = m_valid;
    for (int i = 0; i < N; i++)
      if (v[i] && !m_st2[i] && (m_rg[i] == 2'd1 || m_rg[i] == 2'd2) && (m_sec[i] == !nsb))
        v[i] = 1'b0;
    return v;
  endfunction

  task automatic drive_req(input logic [1:0] el, input bit e2, input bit nsb, input bit nvb,
                           input bit feat, input logic [2:0] o2);
    req_valid = 1; op0 = 2'b01; op1 = 3'b100; crn = 4'b1000; crm = 4'b0001; op2 = o2;
    cur_el = el; el2_en = e2; ns = nsb; nv = nvb; feat_impl = feat;
    tick();
    req_valid = 0;
  endtask

  // kind from R1..R4
  task automatic issue(input logic [1:0] el, input bit e2, input bit nsb, input bit nvb,
                       input bit feat, input logic [2:0] o2, input string tag);
    int k;
    if (!feat || o2 != 3'b000) k = 1;
    else if (el == 2'd0) k = 1;
    else if (el == 2'd1) k = (e2 && nvb) ? 2 : 1;
    else if (el == 2'd2) k = 3;
    else k = e2 ? 3 : 1;
    exp_kind.push_back(k);
    if (k == 3) begin
      exp_valid.push_back(swept(nsb));
      m_valid = swept(nsb);
    end else begin
      exp_valid.push_back(m_valid);
    end
    drive_req(el, e2, nsb, nvb, feat, o2);
    repeat (N + 3) tick();
    chk(valid_vec == m_valid, {tag, " array state"}, 64'(valid_vec), 64'(m_valid));
    if (k == 3) begin
      chk(bcast_req == 1'b1, "R11 broadcast held", 64'(bcast_req), 64'd1);
      repeat (3) tick();
      chk(bcast_req == 1'b1, "R11 broadcast still held", 64'(bcast_req), 64'd1);
      bcast_ack = 1; tick(); bcast_ack = 0;
      chk(bcast_req == 1'b0, "R11 broadcast dropped after ack", 64'(bcast_req), 64'd0);
    end else begin
      chk(bcast_req == 1'b0, "R7 no broadcast when refused", 64'(bcast_req), 64'd0);
    end
  endtask

  initial begin
    rst_n = 0; req_valid = 0; op0 = 0; op1 = 0; crn = 0; crm = 0; op2 = 0;
    cur_el = 0; el2_en = 0; ns = 0; nv = 0; feat_impl = 0;
    fill_en = 0; fill_idx = 0; fill_stage2 = 0; fill_regime = 0; fill_secure = 0; bcast_ack = 0;
    m_valid = '0;
    for (int i = 0; i < N; i++) begin m_st2[i] = 0; m_rg[i] = 0; m_sec[i] = 0; end
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk(valid_vec == '0 && !busy && !done && !bcast_req && !undef_o && !trap_o,
        "reset state", {busy, done, bcast_req, undef_o, trap_o, 51'd0, valid_vec}, 64'd0);

    // R12 fill mix
    fill(0, 0, 2'd1, 0); fill(1, 0, 2'd2, 0); fill(2, 1, 2'd1, 0); fill(3, 0, 2'd0, 0);
    fill(4, 0, 2'd1, 1); fill(5, 0, 2'd2, 1); fill(6, 0, 2'd3, 1);
    chk(valid_vec == 8'h7F, "R12 fill sets valid", 64'(valid_vec), 64'h7F);

    issue(2'd2, 1, 1, 0, 0, 3'b000, "R1 feature absent");
    issue(2'd2, 1, 1, 0, 1, 3'b001, "R1 wrong op2");
    issue(2'd0, 1, 1, 1, 1, 3'b000, "R2 EL0");
    issue(2'd1, 1, 1, 1, 1, 3'b000, "R3 EL1 trap R7");
    issue(2'd1, 1, 1, 0, 1, 3'b000, "R3 EL1 no nv");
    issue(2'd1, 0, 1, 1, 1, 3'b000, "R3 EL1 no el2");
    issue(2'd3, 0, 1, 0, 1, 3'b000, "R4 EL3 el2 off");
    issue(2'd2, 1, 1, 0, 1, 3'b000, "R4 R5 EL2 non-secure");
    chk(valid_vec == 8'h7C, "R5 R6 non-secure clears", 64'(valid_vec), 64'h7C);

    fill(0, 0, 2'd1, 0); fill(1, 0, 2'd2, 0);
    issue(2'd3, 1, 0, 0, 1, 3'b000, "R4 R6 EL3 secure");
    chk(valid_vec == 8'h4F, "R6 secure clears", 64'(valid_vec), 64'h4F);

    // R10 and R6: request during sweep ignored, captured ns kept
    fill(4, 0, 2'd1, 1);
    exp_kind.push_back(3);
    exp_valid.push_back(swept(1'b1));
    m_valid = swept(1'b1);
    drive_req(2'd2, 1, 1, 0, 1, 3'b000);
    tick();
    drive_req(2'd0, 1, 0, 0, 1, 3'b000);
    ns = 0;
    repeat (N + 3) tick();
    chk(valid_vec == 8'h5C, "R10 R6 busy request ignored", 64'(valid_vec), 64'h5C);
    bcast_ack = 1; tick(); bcast_ack = 0;
    chk(bcast_req == 1'b0, "R11 ack clears", 64'(bcast_req), 64'd0);
    chk(exp_kind.size() == 0, "R10 all outcomes seen", 64'(exp_kind.size()), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule